// File: doc/BRIEF.md
# Cascaded Serial Shift Register with Input Select and Loop-Back

This block is a chain of serial shift-register sections. Each section is 64 bits deep. The chain takes one serial bit at its head and gives the bit leaving its tail both in true and in inverted form. Two external serial inputs feed the head, and a select pin picks which one is used. A mode pin can instead close the loop: the tail bit is fed back into the head, so the stored pattern circulates for as long as the pin is held.

A parameter sets the number of sections. A flag parameter picks one of two advance styles:

- **Common-enable style.** Every section shifts on every clock.
- **Staggered style.** A step token walks from the rightmost (tail) section toward the leftmost (head) section, one section per clock. A full chain shift therefore takes as many clocks as there are sections. Because the tail moves before the head, a holding flip-flop keeps the tail bit that will be looped back. The head consumes that bit when its turn comes.

The per-section step vector is brought out as the chain's clock-pass indication.

Top module: `recirc_shift_chain`

## Requirements
- R1: Each section has 64 stages. With loop-back off, a bit accepted at the head appears on `tail_q` after exactly SECTIONS×64 chain shifts. A chain shift is one clock in the common-enable style and SECTIONS clocks in the staggered style.
- R2: With `loop_en` low, `pick_b` low feeds `ser_a` to the head and `pick_b` high feeds `ser_b`. The unselected input has no effect on `tail_q`.
- R3: `tail_qn` is always the inverse of `tail_q`.
- R4: In the common-enable style (DELAYED=0), every bit of `sec_step` is 1 on every clock out of reset.
- R5: In the staggered style (DELAYED=1), `sec_step` is one-hot. Bit SECTIONS-1 (tail section) is set in the first clock after reset. Each clock the set bit moves down by one, and after bit 0 (head section) it wraps back to bit SECTIONS-1.
- R6: With `loop_en` high, the head receives the tail bit of the previous chain shift, so the stored pattern rotates. Both serial inputs are ignored in this mode.
- R7: In the staggered style with loop-back, the holding flip-flop takes `tail_q` on the clock in which the tail section steps. The head takes that held value when it steps, SECTIONS-1 clocks later.
- R8: A synchronous active-high `rst` clears all stages and the holding flip-flop to 0. It also restarts the step token at the tail section. After reset, `tail_q`=0 and `tail_qn`=1.
- R9: In the staggered style, `tail_q` changes only on clock edges where the tail section steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pick_b | input | 1 | Serial input select: 0 = ser_a, 1 = ser_b |
| ser_a | input | 1 | Serial data input A |
| ser_b | input | 1 | Serial data input B |
| loop_en | input | 1 | 1 = loop tail back to head, 0 = external data |
| tail_q | output | 1 | Last stage of the tail section |
| tail_qn | output | 1 | Inverse of tail_q |
| sec_step | output | SECTIONS | Per-section step (clock-pass) indication, bit 0 = head section |

## Verification
The assertions take for granted that `rst` is high from time zero until the first clock edges, so that the token and the stages start from a known state. They also assume reset is released synchronously.

In the staggered style, the selected serial input and `loop_en` matter only on the clock in which the head section steps. The stimulus therefore changes `pick_b`, `loop_en` and the selected input only at chain-shift boundaries. The unselected input, and in loop-back mode both inputs, are toggled randomly on every clock. This shows that they are ignored without making the reference model depend on timing.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  // Bit offered to the head section for one of its serial inputs:
  // either the looped-back tail bit or the external bit.
  function automatic logic feed_src(logic loop_en, logic loop_bit, logic ext_bit);
    return loop_en ? loop_bit : ext_bit;
  endfunction

  // Serial input select inside a section.
  function automatic logic pick_serial(logic pick_b, logic a, logic b);
    return pick_b ? b : a;
  endfunction

endpackage

// File: rtl/rsc_section.sv
module rsc_section
  import rsc_pkg::*;
#(
  parameter int STAGES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic pick_b,
  input  logic din_a,
  input  logic din_b,
  output logic last
);

  logic [STAGES-1:0] stg;
  logic              in_bit;

  assign in_bit = pick_serial(pick_b, din_a, din_b);

  always_ff @(posedge clk) begin
    if (rst)       stg <= '0;
    else if (step) stg <= {stg[STAGES-2:0], in_bit};
  end

  assign last = stg[STAGES-1];

endmodule

// File: rtl/rsc_sequencer.sv
module rsc_sequencer #(
  parameter int SECTIONS = 3,
  parameter bit DELAYED  = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  output logic [SECTIONS-1:0] step
);

  if (!DELAYED) begin : g_common
    assign step = '1;
  end else if (SECTIONS == 1) begin : g_single
    assign step = 1'b1;
  end else begin : g_walk
    localparam logic [SECTIONS-1:0] START = {1'b1, {(SECTIONS-1){1'b0}}};
    logic [SECTIONS-1:0] token;

    // Token moves from the tail section toward the head, then wraps.
    always_ff @(posedge clk) begin
      if (rst) token <= START;
      else     token <= {token[0], token[SECTIONS-1:1]};
    end

    assign step = token;
  end

endmodule

// File: rtl/recirc_shift_chain.sv
module recirc_shift_chain
  import rsc_pkg::*;
#(
  parameter int STAGES   = 64,
  parameter int SECTIONS = 3,
  parameter bit DELAYED  = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pick_b,
  input  logic                ser_a,
  input  logic                ser_b,
  input  logic                loop_en,
  output logic                tail_q,
  output logic                tail_qn,
  output logic [SECTIONS-1:0] sec_step
);

  localparam int TAIL = SECTIONS - 1;

  logic [SECTIONS-1:0] sec_last;
  logic                hold_q;    // holding flip-flop for the looped-back bit
  logic                loop_bit;  // bit the head takes in loop-back mode
  logic                head_a;
  logic                head_b;

  rsc_sequencer #(.SECTIONS(SECTIONS), .DELAYED(DELAYED)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .step (sec_step)
  );

  // Capture the tail bit on the clock in which the tail section steps.
  always_ff @(posedge clk) begin
    if (rst)                 hold_q <= 1'b0;
    else if (sec_step[TAIL]) hold_q <= sec_last[TAIL];
  end

  if (DELAYED) begin : g_loop_held
    assign loop_bit = hold_q;
  end else begin : g_loop_direct
    assign loop_bit = sec_last[TAIL];
  end

  assign head_a = feed_src(loop_en, loop_bit, ser_a);
  assign head_b = feed_src(loop_en, loop_bit, ser_b);

  for (genvar k = 0; k < SECTIONS; k++) begin : g_sec
    if (k == 0) begin : g_head
      rsc_section #(.STAGES(STAGES)) u_sec (
        .clk    (clk),
        .rst    (rst),
        .step   (sec_step[k]),
        .pick_b (pick_b),
        .din_a  (head_a),
        .din_b  (head_b),
        .last   (sec_last[k])
      );
    end else begin : g_body
      rsc_section #(.STAGES(STAGES)) u_sec (
        .clk    (clk),
        .rst    (rst),
        .step   (sec_step[k]),
        .pick_b (1'b0),
        .din_a  (sec_last[k-1]),
        .din_b  (sec_last[k-1]),
        .last   (sec_last[k])
      );
    end
  end

  assign tail_q  = sec_last[TAIL];
  assign tail_qn = ~sec_last[TAIL];

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int SECTIONS = 3,
  parameter bit DELAYED  = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic                tail_q,
  input logic                tail_qn,
  input logic                hold_q,
  input logic [SECTIONS-1:0] sec_step
);

  localparam int TAIL = SECTIONS - 1;
  localparam logic [SECTIONS-1:0] RST_STEP =
    DELAYED ? {1'b1, {(SECTIONS-1){1'b0}}} : {SECTIONS{1'b1}};
  localparam int STEP_CNT = DELAYED ? 1 : SECTIONS;

  // R8 and R3: reset clears the tail and restarts the step pattern.
  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (!tail_q && tail_qn && sec_step == RST_STEP));

  // R4 and R5: number of sections stepping in a clock.
  assert_step_count_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(sec_step) == STEP_CNT);

  if (DELAYED) begin : g_staggered
    // R9: the tail output holds unless the tail section stepped.
    assert_tail_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !sec_step[TAIL] |=> $stable(tail_q));

    // R7: the holding flip-flop takes the pre-step tail bit.
    assert_hold_capture_R7: assert property (@(posedge clk) disable iff (rst)
      sec_step[TAIL] |=> hold_q == $past(tail_q));

    // R5: wrap from the head section back to the tail section.
    assert_token_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      sec_step[0] |=> sec_step[TAIL]);

    // R5: the token walks from each section to its left neighbour.
    for (genvar k = 1; k < SECTIONS; k++) begin : g_walk
      assert_token_walk_R5: assert property (@(posedge clk) disable iff (rst)
        sec_step[k] |=> sec_step[k-1]);
    end
  end

endmodule

bind recirc_shift_chain rsc_checker #(.SECTIONS(SECTIONS), .DELAYED(DELAYED)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tail_q   (tail_q),
  .tail_qn  (tail_qn),
  .hold_q   (hold_q),
  .sec_step (sec_step)
);

// File: tb/tb_recirc_shift_chain.sv
module tb_recirc_shift_chain;

  localparam int ST   = 64;
  localparam int NS_D = 3;  // staggered chain
  localparam int NS_C = 2;  // common-enable chain

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pick_b = 1'b0, ser_a = 1'b0, ser_b = 1'b0, loop_en = 1'b0;
  logic tq_d, tqn_d, tq_c, tqn_c;
  logic [NS_D-1:0] st_d;
  logic [NS_C-1:0] st_c;

  always #2.5 clk = ~clk;

  recirc_shift_chain #(.STAGES(ST), .SECTIONS(NS_D), .DELAYED(1'b1)) dut (
    .clk(clk), .rst(rst), .pick_b(pick_b), .ser_a(ser_a), .ser_b(ser_b),
    .loop_en(loop_en), .tail_q(tq_d), .tail_qn(tqn_d), .sec_step(st_d)
  );

  recirc_shift_chain #(.STAGES(ST), .SECTIONS(NS_C), .DELAYED(1'b0)) dut_direct (
    .clk(clk), .rst(rst), .pick_b(pick_b), .ser_a(ser_a), .ser_b(ser_b),
    .loop_en(loop_en), .tail_q(tq_c), .tail_qn(tqn_c), .sec_step(st_c)
  );

  int checks = 0;
  int fails  = 0;
  int edge_n = 0;
  bit q_d[$];
  bit q_c[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Head bit a chain shift takes, restated from R2 and R6.
  function automatic bit model_in(bit last_bit);
    if (loop_en) return last_bit;
    if (pick_b)  return ser_b;
    return ser_a;
  endfunction

  task automatic clear_models();
    q_d = {};
    q_c = {};
    for (int i = 0; i < NS_D*ST; i++) q_d.push_back(1'b0);
    for (int i = 0; i < NS_C*ST; i++) q_c.push_back(1'b0);
  endtask

  // One clock: update the models for the coming edge, then compare.
  task automatic tick(string tag_d, string tag_c);
    bit nb;
    bit tail_edge;
    tail_edge = (edge_n % NS_D) == 0;
    if (tail_edge) begin
      nb = model_in(q_d[$]);
      q_d.push_front(nb);
      void'(q_d.pop_back());
    end
    nb = model_in(q_c[$]);
    q_c.push_front(nb);
    void'(q_c.pop_back());
    @(posedge clk);
    edge_n++;
    @(negedge clk);
    chk(tail_edge ? tag_d : "R9", 32'(tq_d), 32'(q_d[$]));
    chk("R3", 32'(tqn_d), 32'(!q_d[$]));
    chk(tag_c, 32'(tq_c), 32'(q_c[$]));
    chk("R3", 32'(tqn_c), 32'(!q_c[$]));
    chk("R5", 32'(st_d), 32'(1 << (NS_D - 1 - (edge_n % NS_D))));
    chk("R4", 32'(st_c), 32'({NS_C{1'b1}}));
  endtask

  // One staggered chain shift. The selected input is held for the whole
  // shift; the ignored inputs are toggled on every clock.
  task automatic run_round(bit sb, bit val, bit rc, string tag_d, string tag_c);
    for (int c = 0; c < NS_D; c++) begin
      pick_b  = sb;
      loop_en = rc;
      if (rc) begin
        ser_a = 1'($urandom);
        ser_b = 1'($urandom);
      end else if (sb) begin
        ser_b = val;
        ser_a = 1'($urandom);
      end else begin
        ser_a = val;
        ser_b = 1'($urandom);
      end
      tick(tag_d, tag_c);
    end
  endtask

  task automatic check_reset();
    chk("R8", 32'(tq_d), 32'd0);
    chk("R8", 32'(tqn_d), 32'd1);
    chk("R8", 32'(tq_c), 32'd0);
    chk("R8", 32'(tqn_c), 32'd1);
    chk("R8", 32'(st_d), 32'(1 << (NS_D - 1)));
    chk("R8", 32'(st_c), 32'({NS_C{1'b1}}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    edge_n = 0;
    clear_models();

    // R1: new data on input A, long enough to push bits through the chain.
    for (int r = 0; r < 230; r++) run_round(1'b0, 1'($urandom), 1'b0, "R1", "R1");
    // R2: new data on input B while A toggles.
    for (int r = 0; r < 230; r++) run_round(1'b1, 1'($urandom), 1'b0, "R2", "R2");
    // R6 and R7: loop-back; the pattern must rotate a full turn and more.
    for (int r = 0; r < 250; r++) run_round(r[0], 1'b0, 1'b1, "R7", "R6");
    // Fill with ones, then reset mid-run (R8).
    for (int r = 0; r < 40; r++) run_round(1'b0, 1'b1, 1'b0, "R1", "R1");
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    edge_n = 0;
    clear_models();
    for (int r = 0; r < 30; r++) run_round(1'b1, 1'($urandom), 1'b0, "R8", "R8");
    for (int r = 0; r < 30; r++) run_round(1'b0, 1'b0, 1'b1, "R6", "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule